// File: doc/BRIEF.md
# SIMD Floating-Point Minimum Unit

This block is a vector datapath that takes two packed operand vectors and returns, lane by lane, the smaller of each pair of floating-point elements. One select picks the lane format: half, single or double precision. A second select picks a 64-bit or 128-bit vector. Each lane is evaluated on its own and no lane affects another. The result, an invalid-operation flag and an illegal-configuration indication are registered and appear one clock edge after the inputs are sampled.

Two policies govern NaNs and zeros. In the standard policy, negative zero orders below positive zero. A NaN operand then yields either a quieted copy of one of the input NaNs or the canonical default NaN, as a default-NaN control bit selects. In the alternate policy, any NaN operand, or a pair of zeros, returns the second operand bit for bit. Infinities and subnormal numbers are compared as ordinary encodings, and nothing is flushed to zero.

Top module: `simd_fmin_unit`

## Requirements
- R1: Each active lane outputs the smaller of its two elements under sign-magnitude ordering: any negative value is below any positive value, and between two negatives the one with the larger magnitude is smaller. Infinities and subnormals are ordinary encodings, and nothing is flushed to zero.
- R2: `fmt_sel` 2'b00 selects 16-bit lanes (5 exponent bits, 10 fraction bits), 2'b01 selects 32-bit lanes (8, 23) and 2'b10 selects 64-bit lanes (11, 52). `wide_vec` 0 selects a 64-bit vector and 1 a 128-bit vector. Lane i occupies bits [i*W +: W]. Outputs are registered and reflect the inputs sampled at the previous rising edge.
- R3: When `fmt_sel` is 2'b11, or when it is 2'b10 with `wide_vec` 0, `bad_cfg` is 1, `result` is all zeros and `invalid` is 0. Every other combination gives `bad_cfg` 0.
- R4: With `wide_vec` 0, `result[127:64]` is zero and the upper 64 operand bits have no effect on `result` or `invalid`.
- R5: With `alt_mode` 0, minus zero is below plus zero, so either operand order of (+0, -0) gives -0.
- R6: With `alt_mode` 0 and `dnan_mode` 0, a NaN operand gives a NaN chosen in this order: a signalling NaN in operand a, then a signalling NaN in operand b, then a quiet NaN in a, then b. The chosen NaN has its fraction MSB set to 1.
- R7: With `alt_mode` 0 and `dnan_mode` 1, a NaN operand gives the default NaN: sign 0, exponent all ones, fraction MSB 1 and the other fraction bits 0 (16'h7E00, 32'h7FC00000, 64'h7FF8000000000000).
- R8: With `alt_mode` 1, two zero operands of any signs give operand b unchanged.
- R9: With `alt_mode` 1, a NaN in either operand gives operand b unchanged, whatever the value of `dnan_mode`.
- R10: `invalid` is the OR over active lanes of "either operand is a signalling NaN" (exponent all ones, fraction nonzero, fraction MSB 0), in every mode. Quiet NaNs alone leave it at 0.
- R11: While `rst` is high on a rising edge, `result`, `invalid` and `bad_cfg` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | 128 | First operand vector |
| opnd_b | input | 128 | Second operand vector |
| fmt_sel | input | 2 | Lane format select |
| wide_vec | input | 1 | 1 selects a 128-bit vector, 0 a 64-bit vector |
| alt_mode | input | 1 | Alternate NaN/zero policy |
| dnan_mode | input | 1 | Default-NaN output in the standard policy |
| result | output | 128 | Registered minimum vector |
| invalid | output | 1 | Signalling NaN seen in an active lane |
| bad_cfg | output | 1 | Illegal format and width combination |

## Verification
The bench builds the unit with its default 128-bit maximum vector width. That width places 8, 4 and 2 lanes in the three formats in wide mode, and half as many in narrow mode. Random operands are drawn with a bias towards zeros, infinities, subnormals, quiet and signalling NaNs and equal or negated pairs. Lanes that must not interact therefore often hold special values in neighbouring positions. Directed cases pin the signed-zero ordering, the NaN priority and default NaN, both alternate-policy rules, the masking of the unused upper half, and the illegal double/narrow combination.

// File: rtl/simd_fmin_pkg.sv
package simd_fmin_pkg;

    localparam int MAX_VEC_W   = 128;
    localparam int HALF_EXP_W  = 5;
    localparam int HALF_FRAC_W = 10;
    localparam int SGL_EXP_W   = 8;
    localparam int SGL_FRAC_W  = 23;
    localparam int DBL_EXP_W   = 11;
    localparam int DBL_FRAC_W  = 52;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'b00,
        FMT_SINGLE = 2'b01,
        FMT_DOUBLE = 2'b10,
        FMT_RSVD   = 2'b11
    } lane_fmt_e;

    typedef struct packed {
        logic nan;
        logic snan;
        logic zero;
    } fp_class_t;

    function automatic fp_class_t classify(input logic exp_ones, input logic exp_zero,
                                           input logic frac_zero, input logic frac_msb);
        fp_class_t c;
        c.nan  = exp_ones & ~frac_zero;
        c.snan = exp_ones & ~frac_zero & ~frac_msb;
        c.zero = exp_zero & frac_zero;
        return c;
    endfunction

    function automatic logic is_illegal(input lane_fmt_e fmt, input logic wide);
        return (fmt == FMT_RSVD) || ((fmt == FMT_DOUBLE) && !wide);
    endfunction

endpackage

// File: rtl/fmin_lane.sv
module fmin_lane
    import simd_fmin_pkg::*;
#(
    parameter int EXP_W  = 5,
    parameter int FRAC_W = 10,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         alt,
    input  logic         dn,
    output logic [W-1:0] res,
    output logic         snan_seen
);

    logic [EXP_W-1:0]  ea, eb;
    logic [FRAC_W-1:0] fa, fb;
    fp_class_t         ca, cb;
    logic              a_below;
    logic [W-1:0]      nan_pick;
    logic [W-1:0]      dflt_nan;

    assign ea = a[W-2 -: EXP_W];
    assign eb = b[W-2 -: EXP_W];
    assign fa = a[FRAC_W-1:0];
    assign fb = b[FRAC_W-1:0];
    assign ca = classify(&ea, ~|ea, ~|fa, fa[FRAC_W-1]);
    assign cb = classify(&eb, ~|eb, ~|fb, fb[FRAC_W-1]);
    assign dflt_nan = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    // sign-magnitude ordering; minus zero lands below plus zero naturally
    always_comb begin
        if (a[W-1] != b[W-1])
            a_below = a[W-1];
        else if (a[W-1])
            a_below = a[W-2:0] > b[W-2:0];
        else
            a_below = a[W-2:0] < b[W-2:0];
    end

    always_comb begin
        if (ca.snan)      nan_pick = a;
        else if (cb.snan) nan_pick = b;
        else if (ca.nan)  nan_pick = a;
        else              nan_pick = b;
        nan_pick[FRAC_W-1] = 1'b1;
    end

    always_comb begin
        if (alt) begin
            if (ca.nan || cb.nan || (ca.zero && cb.zero)) res = b;
            else                                          res = a_below ? a : b;
        end else if (ca.nan || cb.nan) begin
            res = dn ? dflt_nan : nan_pick;
        end else begin
            res = a_below ? a : b;
        end
    end

    assign snan_seen = ca.snan | cb.snan;

endmodule

// File: rtl/fmin_format_array.sv
module fmin_format_array #(
    parameter int VEC_W  = 128,
    parameter int EXP_W  = 5,
    parameter int FRAC_W = 10
) (
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    input  logic             wide,
    input  logic             alt,
    input  logic             dn,
    output logic [VEC_W-1:0] res,
    output logic             inv
);

    localparam int LANE_W = 1 + EXP_W + FRAC_W;
    localparam int NLANE  = VEC_W / LANE_W;
    localparam int NHALF  = NLANE / 2;

    logic [NLANE-1:0] lane_inv;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic [LANE_W-1:0] lane_res;
        logic              lane_snan;
        logic              active;

        assign active = (g < NHALF) || wide;

        fmin_lane #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_lane (
            .a         (a[g*LANE_W +: LANE_W]),
            .b         (b[g*LANE_W +: LANE_W]),
            .alt       (alt),
            .dn        (dn),
            .res       (lane_res),
            .snan_seen (lane_snan)
        );

        assign res[g*LANE_W +: LANE_W] = active ? lane_res : '0;
        assign lane_inv[g]             = active & lane_snan;
    end

    assign inv = |lane_inv;

endmodule

// File: rtl/simd_fmin_unit.sv
module simd_fmin_unit
    import simd_fmin_pkg::*;
#(
    parameter int VEC_W = MAX_VEC_W,
    localparam int NARROW_W = VEC_W / 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VEC_W-1:0] opnd_a,
    input  logic [VEC_W-1:0] opnd_b,
    input  logic [1:0]       fmt_sel,
    input  logic             wide_vec,
    input  logic             alt_mode,
    input  logic             dnan_mode,
    output logic [VEC_W-1:0] result,
    output logic             invalid,
    output logic             bad_cfg
);

    lane_fmt_e        fmt;
    logic [VEC_W-1:0] res_h, res_s, res_d, nxt_res;
    logic             inv_h, inv_s, inv_d, nxt_inv, nxt_bad;

    assign fmt = lane_fmt_e'(fmt_sel);

    fmin_format_array #(.VEC_W(VEC_W), .EXP_W(HALF_EXP_W), .FRAC_W(HALF_FRAC_W)) u_half (
        .a(opnd_a), .b(opnd_b), .wide(wide_vec), .alt(alt_mode), .dn(dnan_mode),
        .res(res_h), .inv(inv_h)
    );
    fmin_format_array #(.VEC_W(VEC_W), .EXP_W(SGL_EXP_W), .FRAC_W(SGL_FRAC_W)) u_single (
        .a(opnd_a), .b(opnd_b), .wide(wide_vec), .alt(alt_mode), .dn(dnan_mode),
        .res(res_s), .inv(inv_s)
    );
    fmin_format_array #(.VEC_W(VEC_W), .EXP_W(DBL_EXP_W), .FRAC_W(DBL_FRAC_W)) u_double (
        .a(opnd_a), .b(opnd_b), .wide(wide_vec), .alt(alt_mode), .dn(dnan_mode),
        .res(res_d), .inv(inv_d)
    );

    always_comb begin
        nxt_bad = is_illegal(fmt, wide_vec);
        nxt_res = '0;
        nxt_inv = 1'b0;
        if (!nxt_bad) begin
            case (fmt)
                FMT_HALF:   begin nxt_res = res_h; nxt_inv = inv_h; end
                FMT_SINGLE: begin nxt_res = res_s; nxt_inv = inv_s; end
                default:    begin nxt_res = res_d; nxt_inv = inv_d; end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result  <= '0;
            invalid <= 1'b0;
            bad_cfg <= 1'b0;
        end else begin
            result  <= nxt_res;
            invalid <= nxt_inv;
            bad_cfg <= nxt_bad;
        end
    end

    p_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
        !wide_vec |=> (result[VEC_W-1:NARROW_W] == '0));

    p_illegal_r3: assert property (@(posedge clk) disable iff (rst)
        (fmt_sel == 2'b11 || (fmt_sel == 2'b10 && !wide_vec))
        |=> (bad_cfg && result == '0 && !invalid));

    p_legal_r3: assert property (@(posedge clk) disable iff (rst)
        !(fmt_sel == 2'b11 || (fmt_sel == 2'b10 && !wide_vec)) |=> !bad_cfg);

    p_half_dnan_r7: assert property (@(posedge clk) disable iff (rst)
        (fmt_sel == 2'b00 && !alt_mode && dnan_mode &&
         opnd_a[14:10] == 5'h1f && opnd_a[9:0] != '0)
        |=> (result[15:0] == 16'h7E00));

    p_half_altnan_r9: assert property (@(posedge clk) disable iff (rst)
        (fmt_sel == 2'b00 && alt_mode && opnd_a[14:10] == 5'h1f && opnd_a[9:0] != '0)
        |=> (result[15:0] == $past(opnd_b[15:0])));

endmodule

// File: tb/simd_fmin_unit_test.sv
module simd_fmin_unit_test;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] opnd_a = '0, opnd_b = '0;
    logic [1:0]   fmt_sel = 2'b00;
    logic         wide_vec = 1'b1, alt_mode = 1'b0, dnan_mode = 1'b0;
    logic [127:0] result;
    logic         invalid, bad_cfg;

    int checks = 0;
    int errors = 0;
    logic [127:0] exp_res;
    logic         exp_inv, exp_bad;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_fmin_unit uut (
        .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .fmt_sel(fmt_sel), .wide_vec(wide_vec), .alt_mode(alt_mode),
        .dnan_mode(dnan_mode), .result(result), .invalid(invalid), .bad_cfg(bad_cfg)
    );

    function automatic void fmt_dims(input logic [1:0] f, output int ew, output int fw);
        case (f)
            2'b00:   begin ew = 5;  fw = 10; end
            2'b01:   begin ew = 8;  fw = 23; end
            default: begin ew = 11; fw = 52; end
        endcase
    endfunction

    function automatic void ref_lane(input logic [63:0] a, input logic [63:0] b,
                                     input int ew, input int fw, input logic alt,
                                     input logic dn, output logic [63:0] r, output logic inv);
        int w = 1 + ew + fw;
        logic [63:0] fmask = (64'h1 << fw) - 1;
        logic [63:0] emask = (64'h1 << ew) - 1;
        logic [63:0] qbit  = 64'h1 << (fw - 1);
        logic [63:0] sbit  = 64'h1 << (w - 1);
        logic sa = (a & sbit) != 0, sb = (b & sbit) != 0;
        logic na = (((a >> fw) & emask) == emask) && ((a & fmask) != 0);
        logic nb = (((b >> fw) & emask) == emask) && ((b & fmask) != 0);
        logic qa = (a & qbit) != 0, qb = (b & qbit) != 0;
        logic za = (a & ~sbit) == 0, zb = (b & ~sbit) == 0;
        logic signed [65:0] ka = sa ? -$signed({2'b00, a & ~sbit}) : $signed({2'b00, a & ~sbit});
        logic signed [65:0] kb = sb ? -$signed({2'b00, b & ~sbit}) : $signed({2'b00, b & ~sbit});
        inv = (na && !qa) || (nb && !qb);
        if (alt) begin
            if (na || nb || (za && zb)) r = b;
            else r = (ka < kb) ? a : b;
        end else if (na || nb) begin
            if (dn) r = (emask << fw) | qbit;
            else if (na && !qa) r = a | qbit;
            else if (nb && !qb) r = b | qbit;
            else if (na) r = a | qbit;
            else r = b | qbit;
        end else if (za && zb) begin
            r = sa ? a : b;
        end else begin
            r = (ka < kb) ? a : b;
        end
    endfunction

    function automatic void ref_vec(input logic [127:0] a, input logic [127:0] b,
                                    input logic [1:0] f, input logic wide, input logic alt,
                                    input logic dn, output logic [127:0] r,
                                    output logic inv, output logic bad);
        int ew, fw, lw, nl;
        logic [63:0] mask, lr;
        logic li;
        r = '0; inv = 1'b0;
        bad = (f == 2'b11) || (f == 2'b10 && !wide);
        if (bad) return;
        fmt_dims(f, ew, fw);
        lw = 1 + ew + fw;
        nl = (wide ? 128 : 64) / lw;
        mask = (64'h1 << lw) - 1;
        for (int i = 0; i < nl; i++) begin
            ref_lane(64'(a >> (i*lw)) & mask, 64'(b >> (i*lw)) & mask, ew, fw, alt, dn, lr, li);
            r = r | (128'(lr) << (i*lw));
            inv = inv | li;
        end
    endfunction

    function automatic logic [63:0] gen_lane(input int ew, input int fw, input int kind);
        logic [63:0] fmask = (64'h1 << fw) - 1;
        logic [63:0] emask = (64'h1 << ew) - 1;
        logic [63:0] sgn = {63'b0, 1'($urandom)} << (ew + fw);
        logic [63:0] rnd = {$urandom, $urandom};
        case (kind)
            0:  return sgn;
            1:  return sgn | (emask << fw);
            2:  return sgn | (emask << fw) | (64'h1 << (fw-1)) | (rnd & (fmask >> 1));
            3:  return sgn | (emask << fw) | ((rnd & (fmask >> 1)) | 64'h1);
            4:  return sgn | (rnd & fmask);
            default: return rnd & ((64'h1 << (1 + ew + fw)) - 1);
        endcase
    endfunction

    task automatic step(input string tag);
        ref_vec(opnd_a, opnd_b, fmt_sel, wide_vec, alt_mode, dnan_mode, exp_res, exp_inv, exp_bad);
        @(negedge clk);
        checks++;
        if (result !== exp_res || invalid !== exp_inv || bad_cfg !== exp_bad) begin
            errors++;
            $display("FAIL %s: got res=%h inv=%b bad=%b expected res=%h inv=%b bad=%b",
                     tag, result, invalid, bad_cfg, exp_res, exp_inv, exp_bad);
        end
    endtask

    task automatic drive(input logic [127:0] a, input logic [127:0] b, input logic [1:0] f,
                         input logic w, input logic al, input logic d);
        opnd_a = a; opnd_b = b; fmt_sel = f; wide_vec = w; alt_mode = al; dnan_mode = d;
    endtask

    task automatic expect_lane(input string tag, input logic [63:0] got, input logic [63:0] want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, want);
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11 reset state
        checks++;
        if (result !== '0 || invalid !== 1'b0 || bad_cfg !== 1'b0) begin
            errors++;
            $display("FAIL R11: got res=%h inv=%b bad=%b expected zeros", result, invalid, bad_cfg);
        end
        rst = 1'b0;

        // R5 signed zero ordering, both orders
        drive(128'h8000, 128'h0000, 2'b00, 1'b1, 1'b0, 1'b0); step("R5 -0,+0");
        expect_lane("R5 -0,+0 lane", 64'(result[15:0]), 64'h8000);
        drive(128'h0000, 128'h8000, 2'b00, 1'b1, 1'b0, 1'b0); step("R5 +0,-0");
        expect_lane("R5 +0,-0 lane", 64'(result[15:0]), 64'h8000);

        // R8 alternate zeros give b
        drive(128'h8000, 128'h0000, 2'b00, 1'b1, 1'b1, 1'b0); step("R8 alt zeros");
        expect_lane("R8 alt zeros lane", 64'(result[15:0]), 64'h0000);

        // R9 alternate NaN gives b despite default-NaN mode
        drive(128'h7E00, 128'h3C00, 2'b00, 1'b1, 1'b1, 1'b1); step("R9 alt nan");
        expect_lane("R9 alt nan lane", 64'(result[15:0]), 64'h3C00);

        // R7 default NaN, single precision, signalling input
        drive(128'h7F800001, 128'h3F800000, 2'b01, 1'b1, 1'b0, 1'b1); step("R7 dn single");
        expect_lane("R7 dn single lane", 64'(result[31:0]), 64'h7FC00000);
        expect_lane("R10 snan flag", 64'(invalid), 64'h1);

        // R6 priority: signalling b beats quiet a
        drive(128'h7E05, 128'h7C03, 2'b00, 1'b1, 1'b0, 1'b0); step("R6 nan priority");
        expect_lane("R6 nan priority lane", 64'(result[15:0]), 64'h7E03);

        // R10 quiet NaN alone leaves flag clear
        drive(128'h7E05, 128'h3C00, 2'b00, 1'b1, 1'b0, 1'b0); step("R10 quiet only");
        expect_lane("R10 quiet only flag", 64'(invalid), 64'h0);

        // R3 illegal combinations
        drive('1, '1, 2'b10, 1'b0, 1'b0, 1'b0); step("R3 double narrow");
        expect_lane("R3 bad_cfg", 64'(bad_cfg), 64'h1);
        drive('1, '1, 2'b11, 1'b1, 1'b0, 1'b0); step("R3 reserved fmt");

        // R4 upper half ignored in narrow mode
        drive({64'h7F800001_7F800001, 64'h3F800000_BF800000},
              {64'h7F800001_7F800001, 64'h40000000_C0000000}, 2'b01, 1'b0, 1'b0, 1'b0);
        step("R4 narrow upper ignored");
        expect_lane("R4 upper zero", result[127:64], 64'h0);
        expect_lane("R4 no flag from upper", 64'(invalid), 64'h0);

        // R1 / R2 double lanes, infinity and subnormal ordering
        drive({64'hFFF0000000000000, 64'h0000000000000001},
              {64'hC000000000000000, 64'h0000000000000002}, 2'b10, 1'b1, 1'b0, 1'b0);
        step("R2 double wide");
        expect_lane("R1 -inf lane1", result[127:64], 64'hFFF0000000000000);
        expect_lane("R1 subnormal lane0", result[63:0], 64'h0000000000000001);

        // R1 random mix across formats and modes
        for (int it = 0; it < 3000; it++) begin
            int ew, fw, lw, nl;
            logic [127:0] ra, rb;
            logic [1:0] f = 2'($urandom_range(0, 3));
            fmt_dims(f, ew, fw);
            lw = 1 + ew + fw;
            nl = 128 / lw;
            ra = {$urandom, $urandom, $urandom, $urandom};
            rb = {$urandom, $urandom, $urandom, $urandom};
            for (int l = 0; l < nl; l++) begin
                logic [63:0] va = gen_lane(ew, fw, $urandom_range(0, 9));
                logic [63:0] vb = gen_lane(ew, fw, $urandom_range(0, 9));
                int pick = $urandom_range(0, 5);
                if (pick == 0) vb = va;
                if (pick == 1) vb = va ^ (64'h1 << (lw - 1));
                ra = (ra & ~(128'((64'h1 << lw) - 1) << (l*lw))) | (128'(va) << (l*lw));
                rb = (rb & ~(128'((64'h1 << lw) - 1) << (l*lw))) | (128'(vb) << (l*lw));
            end
            drive(ra, rb, f, 1'($urandom), 1'($urandom), 1'($urandom));
            step("R1 random");
        end

        // R11 reset clears a nonzero state
        drive('1, '1, 2'b00, 1'b1, 1'b0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        checks++;
        if (result !== '0 || invalid !== 1'b0 || bad_cfg !== 1'b0) begin
            errors++;
            $display("FAIL R11 reassert: got res=%h inv=%b bad=%b expected zeros",
                     result, invalid, bad_cfg);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule